// File: doc/BRIEF.md
# Pipelined Fixed-Point Vector Rotator

This block rotates a two-dimensional fixed-point vector by a signed angle. It uses only shifts, additions, subtractions and sign tests, with no multiplier. A new vector and angle can be presented on every clock. Each one moves through a fixed-depth pipeline and comes out rotated, with unit gain, a constant number of cycles later, in the order it went in.

The first pipeline stage makes a coarse quarter-turn. It turns the vector by +90 or -90 degrees by exchanging the two coordinates and negating one of them, and it adjusts the angle residual to match. A chain of micro-rotation stages follows. The stages shrink in size in strictly decreasing order: stage i turns by atan(2^-i). Each stage picks its direction from the sign of the angle residual it receives and passes the updated residual on. A last stage multiplies both coordinates by the constant CORDIC gain correction (about 0.6073), using a fixed set of shifted additions. It then rounds the result back to the port format.

Data words carry two integer bits: a sign and one more. The remaining bits are fraction, so +1.0 is 2^(DW-2). Angles are signed binary radians, where the full angle word spans one turn. The number of micro-rotations equals the fractional width of the data word.

Top module: `cordic_rotator`

## Requirements
- R1: For inputs with both coordinates in [-1.0, +1.0], out_x is within 6 LSB of x·cosφ − y·sinφ and out_y is within 6 LSB of y·cosφ + x·sinφ, where φ is the requested angle.
- R2: out_valid is high in the cycle after the (DW)-th rising edge, counting from the edge that samples in_valid high. This is 16 edges with the defaults, and out_valid is high in no other cycle.
- R3: Back-to-back inputs, one per clock, produce one result per clock, in input order.
- R4: While rst_n is low, and after it is released before any input, out_valid is 0 and out_x and out_y are 0.
- R5: Data format: a DW-bit two's complement word with DW-2 fraction bits. +1.0 is 2^(DW-2) (16384 for DW=16) and -1.0 is -2^(DW-2). Rotating (1.0, 0) by angle 0 returns (16384, 0) within the R1 tolerance.
- R6: Angle format: an AW-bit two's complement word in which code c means c·π/2^(AW-1). +π/2 is 2^(AW-2), and (1.0, 0) rotated by +π/2 gives (0, 1.0).
- R7: The coarse step turns by +90 degrees for angle codes ≥ 0 and by -90 degrees for negative codes. Every code, including the most negative code (−π) and the codes next to zero, gives the correctly rotated vector.
- R8: out_x and out_y hold their value in every cycle in which out_valid is low.
- R9: Cycles with in_valid low create no result. Gaps in the input appear as the same gaps in out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector and angle are valid this cycle |
| in_x | input | DW | Input x coordinate, two integer bits |
| in_y | input | DW | Input y coordinate, two integer bits |
| in_angle | input | AW | Rotation angle, signed binary radians |
| out_valid | output | 1 | Rotated result valid this cycle |
| out_x | output | DW | Rotated x coordinate |
| out_y | output | DW | Rotated y coordinate |

## Verification
Every accepted input is due exactly DW register stages later, so with the defaults its result is present after the sixteenth rising edge counted from the sampling edge. The bench stamps each expected result with that edge number when it drives the input. At every falling edge it compares the design against the oldest stamp: out_valid must be high exactly when a stamp falls due, and low otherwise. The expected coordinates come from floating-point cosine and sine of the decoded angle and are compared within the stated tolerance. Between results, the bench checks that the outputs keep the last value it saw.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    localparam real PI_C = 3.14159265358979323846;

    // angle code of atan(2^-i) in a word where 2^(aw-1) means pi
    function automatic int atan_code(input int i, input int aw);
        real a;
        a = $atan(1.0 / (2.0 ** i));
        return $rtoi(a / PI_C * (2.0 ** (aw - 1)) + 0.5);
    endfunction

    // gain correction for n micro-rotations, fb fraction bits
    function automatic longint gain_code(input int n, input int fb);
        real k;
        k = 1.0;
        for (int j = 0; j < n; j++) begin
            k = k / $sqrt(1.0 + 2.0 ** (-2 * j));
        end
        return longint'($rtoi(k * (2.0 ** fb) + 0.5));
    endfunction

endpackage

// File: rtl/cordic_coarse_stage.sv
module cordic_coarse_stage #(
    parameter int DW    = 16,
    parameter int AW    = 20,
    parameter int GUARD = 3,
    parameter int IW    = DW + 2 + GUARD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [AW-1:0] ang_in,
    output logic                 valid_out,
    output logic signed [IW-1:0] x_out,
    output logic signed [IW-1:0] y_out,
    output logic signed [AW-1:0] z_out
);
    localparam logic signed [AW-1:0] QUARTER = AW'(1) <<< (AW - 2);

    typedef struct packed {
        logic                 valid;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [AW-1:0] z;
    } coarse_t;

    coarse_t st_d, st_q;
    logic signed [IW-1:0] xe, ye;

    always_comb begin
        xe   = {{(IW - DW){x_in[DW-1]}}, x_in} <<< GUARD;
        ye   = {{(IW - DW){y_in[DW-1]}}, y_in} <<< GUARD;
        st_d = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            if (!ang_in[AW-1]) begin
                st_d.x = -ye;
                st_d.y = xe;
                st_d.z = ang_in - QUARTER;
            end else begin
                st_d.x = ye;
                st_d.y = -xe;
                st_d.z = ang_in + QUARTER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out = st_q.valid;
    assign x_out     = st_q.x;
    assign y_out     = st_q.y;
    assign z_out     = st_q.z;

    // R7: after the quarter turn the residual lies within [-pi/2, +pi/2)
    p_residual_quarter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (z_out[AW-1] == z_out[AW-2]));

endmodule

// File: rtl/cordic_micro_stage.sv
module cordic_micro_stage #(
    parameter int              IW    = 21,
    parameter int              AW    = 20,
    parameter int              SHIFT = 0,
    parameter logic [AW-1:0]   ATAN  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    input  logic signed [AW-1:0] z_in,
    output logic                 valid_out,
    output logic signed [IW-1:0] x_out,
    output logic signed [IW-1:0] y_out,
    output logic signed [AW-1:0] z_out
);
    typedef struct packed {
        logic                 valid;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [AW-1:0] z;
    } micro_t;

    micro_t st_d, st_q;
    logic signed [IW-1:0] xs, ys;

    always_comb begin
        xs   = x_in >>> SHIFT;
        ys   = y_in >>> SHIFT;
        st_d = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            if (!z_in[AW-1]) begin
                st_d.x = x_in - ys;
                st_d.y = y_in + xs;
                st_d.z = z_in - $signed(ATAN);
            end else begin
                st_d.x = x_in + ys;
                st_d.y = y_in - xs;
                st_d.z = z_in + $signed(ATAN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out = st_q.valid;
    assign x_out     = st_q.x;
    assign y_out     = st_q.y;
    assign z_out     = st_q.z;

    // R1: intermediate coordinates keep headroom (no wrap of the top bit)
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (x_out[IW-1] == x_out[IW-2]) && (y_out[IW-1] == y_out[IW-2]));

endmodule

// File: rtl/cordic_gain_stage.sv
module cordic_gain_stage #(
    parameter int DW    = 16,
    parameter int GUARD = 3,
    parameter int ITER  = 14,
    parameter int IW    = DW + 2 + GUARD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    output logic                 valid_out,
    output logic signed [DW-1:0] x_out,
    output logic signed [DW-1:0] y_out
);
    import cordic_rot_pkg::*;

    localparam int            KB    = IW;
    localparam int            ACCW  = IW + 2;
    localparam int            FRAC  = DW - 2;
    localparam logic [KB-1:0] KCODE = KB'(gain_code(ITER, KB));
    localparam logic signed [ACCW-1:0] RND  = ACCW'(1) <<< (GUARD - 1);
    localparam logic signed [ACCW-1:0] OMAX = ACCW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] OMIN = -(ACCW'(1) <<< (DW - 1));
    localparam logic signed [DW-1:0]   LIM  = DW'(3) <<< (FRAC - 1);

    typedef struct packed {
        logic                 valid;
        logic signed [DW-1:0] x;
        logic signed [DW-1:0] y;
    } gain_t;

    gain_t st_d, st_q;
    logic signed [ACCW-1:0] xw, yw, xacc, yacc, xr, yr;

    always_comb begin
        xw   = {{2{x_in[IW-1]}}, x_in};
        yw   = {{2{y_in[IW-1]}}, y_in};
        xacc = '0;
        yacc = '0;
        for (int j = 1; j <= KB; j++) begin
            if (KCODE[KB-j]) begin
                xacc = xacc + (xw >>> j);
                yacc = yacc + (yw >>> j);
            end
        end
        xr = (xacc + RND) >>> GUARD;
        yr = (yacc + RND) >>> GUARD;
        if (xr > OMAX) xr = OMAX;
        if (xr < OMIN) xr = OMIN;
        if (yr > OMAX) yr = OMAX;
        if (yr < OMIN) yr = OMIN;
        st_d = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.x = xr[DW-1:0];
            st_d.y = yr[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out = st_q.valid;
    assign x_out     = st_q.x;
    assign y_out     = st_q.y;

    // R8: results hold while no new one is presented
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> ($stable(x_out) && $stable(y_out)));

    // R5: unit-gain results of in-range inputs stay below 1.5 in magnitude
    p_out_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (x_out <= LIM) && (x_out >= -LIM) && (y_out <= LIM) && (y_out >= -LIM));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
    parameter int DW    = 16,
    parameter int AW    = 20,
    parameter int GUARD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [AW-1:0] in_angle,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y
);
    import cordic_rot_pkg::*;

    localparam int FRAC = DW - 2;
    localparam int ITER = FRAC;
    localparam int IW   = DW + 2 + GUARD;
    localparam int LAT  = ITER + 2;
    localparam int CW   = $clog2(LAT + 2) + 1;

    logic                 v_s [ITER+1];
    logic signed [IW-1:0] x_s [ITER+1];
    logic signed [IW-1:0] y_s [ITER+1];
    logic signed [AW-1:0] z_s [ITER+1];

    cordic_coarse_stage #(.DW(DW), .AW(AW), .GUARD(GUARD), .IW(IW)) u_coarse (
        .clk(clk), .rst_n(rst_n), .valid_in(in_valid),
        .x_in(in_x), .y_in(in_y), .ang_in(in_angle),
        .valid_out(v_s[0]), .x_out(x_s[0]), .y_out(y_s[0]), .z_out(z_s[0])
    );

    for (genvar i = 0; i < ITER; i++) begin : g_micro
        localparam logic [AW-1:0] ACODE = AW'(atan_code(i, AW));
        cordic_micro_stage #(.IW(IW), .AW(AW), .SHIFT(i), .ATAN(ACODE)) u_stage (
            .clk(clk), .rst_n(rst_n), .valid_in(v_s[i]),
            .x_in(x_s[i]), .y_in(y_s[i]), .z_in(z_s[i]),
            .valid_out(v_s[i+1]), .x_out(x_s[i+1]), .y_out(y_s[i+1]), .z_out(z_s[i+1])
        );
    end

    cordic_gain_stage #(.DW(DW), .GUARD(GUARD), .ITER(ITER), .IW(IW)) u_gain (
        .clk(clk), .rst_n(rst_n), .valid_in(v_s[ITER]),
        .x_in(x_s[ITER]), .y_in(y_s[ITER]),
        .valid_out(out_valid), .x_out(out_x), .y_out(out_y)
    );

    // checker state: number of accepted inputs not yet delivered
    logic [CW-1:0] inflight_d, inflight_q;

    always_comb begin
        inflight_d = inflight_q + CW'(in_valid) - CW'(out_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_d;
    end

    // R9: a result only appears for an input that was accepted earlier
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0));

    // R2: no more inputs in flight than pipeline stages
    p_inflight_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CW'(LAT));

endmodule

// File: tb/cordic_rotator_tb.sv
module cordic_rotator_tb;
    localparam int  DW   = 16;
    localparam int  AW   = 20;
    localparam int  FRAC = DW - 2;
    localparam int  LAT  = FRAC + 2;
    localparam int  ONE  = 1 << FRAC;
    localparam int  TOL  = 6;
    localparam real PI_R = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic signed [AW-1:0] in_angle = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_x, out_y;

    always #5 clk = ~clk;

    cordic_rotator #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_angle(in_angle),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    typedef struct {
        int    due;
        int    ex;
        int    ey;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   last_x = 0;
    int   last_y = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check(out_valid == 1'b0, "R4", "out_valid in reset", int'(out_valid), 0);
                check(out_x == 0 && out_y == 0, "R4", "out_x in reset", int'(out_x), 0);
            end else if (q.size() != 0 && q[0].due == cyc) begin
                check(out_valid == 1'b1, "R2", "out_valid when due", int'(out_valid), 1);
                check(iabs(int'(out_x) - q[0].ex) <= TOL, q[0].tag, "out_x", int'(out_x), q[0].ex);
                check(iabs(int'(out_y) - q[0].ey) <= TOL, q[0].tag, "out_y", int'(out_y), q[0].ey);
                last_x = int'(out_x);
                last_y = int'(out_y);
                void'(q.pop_front());
            end else begin
                check(out_valid == 1'b0, "R9", "out_valid when nothing due", int'(out_valid), 0);
                check(int'(out_x) == last_x, "R8", "out_x held", int'(out_x), last_x);
                check(int'(out_y) == last_y, "R8", "out_y held", int'(out_y), last_y);
            end
        end
    end

    // drive one input at a falling edge; it is sampled at the next rising edge
    task automatic send(input int x, input int y, input int a, input string tag);
        exp_t e;
        real  phi, xr, yr;
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = DW'(x);
        in_y     = DW'(y);
        in_angle = AW'(a);
        phi = real'(a) * PI_R / (2.0 ** (AW - 1));
        xr  = real'(x) * $cos(phi) - real'(y) * $sin(phi);
        yr  = real'(y) * $cos(phi) + real'(x) * $sin(phi);
        e.due = cyc + LAT;
        e.ex  = $rtoi(xr + ((xr < 0.0) ? -0.5 : 0.5));
        e.ey  = $rtoi(yr + ((yr < 0.0) ? -0.5 : 0.5));
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int rnd_coord();
        return int'($urandom_range(2 * ONE)) - ONE;
    endfunction

    function automatic int rnd_angle();
        return int'($urandom_range((1 << AW) - 1)) - (1 << (AW - 1));
    endfunction

    initial begin
        // R4: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R5: unit vector, zero angle
        send(ONE, 0, 0, "R5");
        idle(LAT + 2);
        // R6: quarter turn positive
        send(ONE, 0, 1 << (AW - 2), "R6");
        idle(2);
        // R7: most negative code, codes on both sides of zero, -pi/2
        send(ONE, 0, -(1 << (AW - 1)), "R7");
        send(0, ONE, -1, "R7");
        send(0, ONE, 0, "R7");
        send(ONE / 2, -ONE / 2, -(1 << (AW - 2)), "R7");
        send(-ONE, -ONE, (1 << (AW - 1)) - 1, "R7");
        send(-ONE, ONE, 1 << (AW - 3), "R7");
        idle(LAT + 3);

        // R1: varied vectors and angles, with gaps (R9)
        for (int k = 0; k < 60; k++) begin
            send(rnd_coord(), rnd_coord(), rnd_angle(), "R1");
            if (k % 3 == 0) idle(1 + k % 4);
        end
        idle(LAT + 2);

        // R3: back-to-back burst, one result per clock, in order
        for (int k = 0; k < 50; k++) begin
            send(rnd_coord(), rnd_coord(), rnd_angle(), "R3");
        end
        idle(LAT + 4);

        // R9: alternating valid pattern
        for (int k = 0; k < 20; k++) begin
            send(rnd_coord(), rnd_coord(), rnd_angle(), "R9");
            idle(1);
        end
        idle(LAT + 4);

        check(q.size() == 0, "R2", "results outstanding", q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule